// File: doc/BRIEF.md
# Privilege-Aware General Register File

This block is the general-purpose register store of a small RISC core: thirty-two words of thirty-two bits, two combinational read ports and one clocked write port. Every access is checked against two inputs from the core. The first says whether the core runs in user mode. The second says whether the debug agent owns the access. An access that the current context may not make is disabled. A blocked read returns zero and a blocked write is dropped. In both cases a single violation flag is raised in the same cycle. The core's exception logic decides what to do with that flag, because this block never traps.

Register 0 is hardwired to zero. Two registers hold exception state and are closed to user mode. Two more belong to the debug agent. A subroutine call drives a link strobe with the return address, and that strobe takes over the write port to load register 31. A write in flight is forwarded to a read of the same register in the same cycle, so the core needs no bypass network of its own.

Top module: `prf_regfile`

## Requirements
- R1: Asserting `rst_n` low clears every register to zero at once. Release is synchronised by two flops, so writes take effect from the third rising edge after `rst_n` goes high.
- R2: A read of register 0 always returns zero, and a write to register 0 is discarded.
- R3: A write (`wr_en`=1) to a permitted nonzero address is stored on the rising clock edge. Both read ports are combinational and may address any registers at the same time.
- R4: A permitted write that is pending in the current cycle is forwarded to any read port that addresses the same register in that cycle.
- R5: While `user_mode`=1, registers 24 and 29 are blocked: reads of them return zero and writes to them are suppressed. While `user_mode`=0 they behave like ordinary registers.
- R6: Registers 25 and 30 are blocked in either mode unless `dbg_access`=1, with the same zero-read and write-suppression behaviour as R5.
- R7: `violation` is high, combinationally in the same cycle, exactly when an enabled read port (`rd_en_a`/`rd_en_b`=1) addresses a blocked register, or when a write that is not overridden by the link strobe targets a blocked register. A read port with its enable low reads without raising the flag.
- R8: When `link_en`=1, `link_data` is written to register 31 on the rising edge and is forwarded to reads of register 31 in that cycle. The normal write inputs are ignored for that cycle and cannot raise `violation`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_en_a | input | 1 | Read port A access is live (qualifies violation) |
| rd_data_a | output | 32 | Read port A data |
| rd_addr_b | input | 5 | Read port B address |
| rd_en_b | input | 1 | Read port B access is live (qualifies violation) |
| rd_data_b | output | 32 | Read port B data |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write request |
| link_en | input | 1 | Subroutine-call strobe: load register 31 |
| link_data | input | 32 | Return address for register 31 |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| dbg_access | input | 1 | 1 = access made on behalf of the debug agent |
| violation | output | 1 | A blocked access was attempted this cycle |

## Verification
A corrupted stored word stays hidden until a read addresses it. A mis-decoded write enable shows up on the next read of either the intended register or the one hit by mistake, one edge after the write. Faults in privilege decoding or bypass selection are visible in the same cycle, on the read data or on `violation`, because both are combinational. The bench reads through both ports on every cycle and keeps a model of all thirty-two words, so any stored error surfaces at the first access to that register.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [1:0] {
    ACC_OPEN  = 2'd0,
    ACC_SUPER = 2'd1,
    ACC_DEBUG = 2'd2
  } acc_cls_e;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/prf_rst_sync.sv
module prf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/prf_access_gate.sv
module prf_access_gate
  import prf_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned EXC_REG_A = 24,
  parameter int unsigned EXC_REG_B = 29,
  parameter int unsigned DBG_REG_A = 25,
  parameter int unsigned DBG_REG_B = 30
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              user_mode,
  input  logic              dbg_access,
  output logic              permitted
);

  acc_cls_e cls;

  always_comb begin
    if (addr == ADDR_W'(EXC_REG_A) || addr == ADDR_W'(EXC_REG_B)) begin
      cls = ACC_SUPER;
    end else if (addr == ADDR_W'(DBG_REG_A) || addr == ADDR_W'(DBG_REG_B)) begin
      cls = ACC_DEBUG;
    end else begin
      cls = ACC_OPEN;
    end
  end

  always_comb begin
    unique case (cls)
      ACC_SUPER: permitted = !user_mode;
      ACC_DEBUG: permitted = dbg_access;
      default:   permitted = 1'b1;
    endcase
  end

endmodule

// File: rtl/prf_store.sv
module prf_store #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_fire,
  input  logic [ADDR_W-1:0]                wr_sel,
  input  logic [DATA_W-1:0]                wr_val,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs_o[g] = '0;
    end else begin : g_word
      logic              en;
      logic [DATA_W-1:0] word_d;
      logic [DATA_W-1:0] word_q;

      always_comb begin
        en     = wr_fire && (wr_sel == ADDR_W'(g));
        word_d = en ? wr_val : word_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          word_q <= '0;
        end else if (en) begin
          word_q <= word_d;
        end
      end

      assign regs_o[g] = word_q;
    end
  end

endmodule

// File: rtl/prf_read_port.sv
module prf_read_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             permitted,
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  input  logic                             byp_fire,
  input  logic [ADDR_W-1:0]                byp_sel,
  input  logic [DATA_W-1:0]                byp_val,
  output logic [DATA_W-1:0]                data
);

  logic              hit;
  logic [DATA_W-1:0] raw;

  always_comb begin
    hit = byp_fire && (byp_sel == addr);
    raw = hit ? byp_val : regs[addr];
    data = permitted ? raw : '0;
  end

endmodule

// File: rtl/prf_regfile.sv
module prf_regfile
  import prf_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned EXC_REG_A = 24,
  parameter int unsigned EXC_REG_B = 29,
  parameter int unsigned DBG_REG_A = 25,
  parameter int unsigned DBG_REG_B = 30,
  parameter int unsigned LINK_REG  = 31
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_addr_a,
  input  logic                          rd_en_a,
  output logic [DATA_W-1:0]             rd_data_a,
  input  logic [$clog2(NUM_REGS)-1:0]   rd_addr_b,
  input  logic                          rd_en_b,
  output logic [DATA_W-1:0]             rd_data_b,
  input  logic [$clog2(NUM_REGS)-1:0]   wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          wr_en,
  input  logic                          link_en,
  input  logic [DATA_W-1:0]             link_data,
  input  logic                          user_mode,
  input  logic                          dbg_access,
  output logic                          violation
);

  localparam int unsigned ADDR_W  = $clog2(NUM_REGS);
  localparam int unsigned N_RD    = 2;
  localparam int unsigned N_CHK   = N_RD + 1;
  localparam int unsigned WR_SLOT = N_RD;

  logic rst_n_sync;

  prf_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  // Access checks: slots 0..N_RD-1 are read ports, last slot is the write port.
  logic [ADDR_W-1:0] chk_addr [N_CHK];
  logic [N_CHK-1:0]  chk_ok;
  logic [N_CHK-1:0]  chk_live;

  assign chk_addr[0]       = rd_addr_a;
  assign chk_addr[1]       = rd_addr_b;
  assign chk_addr[WR_SLOT] = wr_addr;

  for (genvar p = 0; p < N_CHK; p++) begin : g_gate
    prf_access_gate #(
      .ADDR_W   (ADDR_W),
      .EXC_REG_A(EXC_REG_A),
      .EXC_REG_B(EXC_REG_B),
      .DBG_REG_A(DBG_REG_A),
      .DBG_REG_B(DBG_REG_B)
    ) u_gate (
      .addr      (chk_addr[p]),
      .user_mode (user_mode),
      .dbg_access(dbg_access),
      .permitted (chk_ok[p])
    );
  end

  // Write-port arbitration: the link strobe owns the port when high.
  logic              eff_fire;
  logic [ADDR_W-1:0] eff_sel;
  logic [DATA_W-1:0] eff_val;
  logic              plain_wr;

  always_comb begin
    plain_wr = wr_en && !link_en;
    if (link_en) begin
      eff_fire = 1'b1;
      eff_sel  = ADDR_W'(LINK_REG);
      eff_val  = link_data;
    end else begin
      eff_fire = wr_en && chk_ok[WR_SLOT] && (wr_addr != '0);
      eff_sel  = wr_addr;
      eff_val  = wr_data;
    end
  end

  always_comb begin
    chk_live[0]       = rd_en_a;
    chk_live[1]       = rd_en_b;
    chk_live[WR_SLOT] = plain_wr;
    violation         = |(chk_live & ~chk_ok);
  end

  logic [NUM_REGS-1:0][DATA_W-1:0] regs;

  prf_store #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_fire(eff_fire),
    .wr_sel (eff_sel),
    .wr_val (eff_val),
    .regs_o (regs)
  );

  logic [DATA_W-1:0] rd_word [N_RD];

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    prf_read_port #(
      .DATA_W  (DATA_W),
      .NUM_REGS(NUM_REGS),
      .ADDR_W  (ADDR_W)
    ) u_rd (
      .addr     (chk_addr[r]),
      .permitted(chk_ok[r]),
      .regs     (regs),
      .byp_fire (eff_fire),
      .byp_sel  (eff_sel),
      .byp_val  (eff_val),
      .data     (rd_word[r])
    );
  end

  assign rd_data_a = rd_word[0];
  assign rd_data_b = rd_word[1];

endmodule

// File: rtl/prf_regfile_checker.sv
module prf_regfile_checker #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned EXC_REG_A = 24,
  parameter int unsigned EXC_REG_B = 29,
  parameter int unsigned DBG_REG_A = 25,
  parameter int unsigned DBG_REG_B = 30,
  parameter int unsigned LINK_REG  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_addr_a,
  input logic              rd_en_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic [ADDR_W-1:0] rd_addr_b,
  input logic              rd_en_b,
  input logic [DATA_W-1:0] rd_data_b,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_en,
  input logic              link_en,
  input logic [DATA_W-1:0] link_data,
  input logic              user_mode,
  input logic              dbg_access,
  input logic              violation
);

  logic b_exc, a_dbg, wr_open, b_link_quiet;

  always_comb begin
    b_exc   = (rd_addr_b == ADDR_W'(EXC_REG_A)) || (rd_addr_b == ADDR_W'(EXC_REG_B));
    a_dbg   = (rd_addr_a == ADDR_W'(DBG_REG_A)) || (rd_addr_a == ADDR_W'(DBG_REG_B));
    wr_open = (wr_addr != '0) &&
              (wr_addr != ADDR_W'(EXC_REG_A)) && (wr_addr != ADDR_W'(EXC_REG_B)) &&
              (wr_addr != ADDR_W'(DBG_REG_A)) && (wr_addr != ADDR_W'(DBG_REG_B));
    b_link_quiet = (rd_addr_b == ADDR_W'(LINK_REG)) && !link_en &&
                   !(wr_en && wr_addr == ADDR_W'(LINK_REG));
  end

  p_zero_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  p_exc_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && b_exc) |-> ((rd_data_b == '0) && (!rd_en_b || violation)));

  p_dbg_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_access && a_dbg && rd_en_a) |-> (violation && rd_data_a == '0));

  p_bypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !link_en && wr_open && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));

  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_a && !rd_en_b && !wr_en) |-> !violation);

  p_link_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_en |=> (!b_link_quiet || rd_data_b == $past(link_data)));

endmodule

bind prf_regfile prf_regfile_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .EXC_REG_A(EXC_REG_A),
  .EXC_REG_B(EXC_REG_B),
  .DBG_REG_A(DBG_REG_A),
  .DBG_REG_B(DBG_REG_B),
  .LINK_REG (LINK_REG)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .rd_addr_a (rd_addr_a),
  .rd_en_a   (rd_en_a),
  .rd_data_a (rd_data_a),
  .rd_addr_b (rd_addr_b),
  .rd_en_b   (rd_en_b),
  .rd_data_b (rd_data_b),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_en     (wr_en),
  .link_en   (link_en),
  .link_data (link_data),
  .user_mode (user_mode),
  .dbg_access(dbg_access),
  .violation (violation)
);

// File: tb/prf_regfile_tb.sv
`timescale 1ns/1ps
module prf_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic        rd_en_a, rd_en_b, wr_en, link_en, user_mode, dbg_access;
  logic [31:0] wr_data, link_data;
  logic [31:0] rd_data_a, rd_data_b;
  logic        violation;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [32];

  always #2.5 clk = ~clk;

  prf_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_en_a(rd_en_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_en_b(rd_en_b), .rd_data_b(rd_data_b),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en),
    .link_en(link_en), .link_data(link_data),
    .user_mode(user_mode), .dbg_access(dbg_access), .violation(violation)
  );

  function automatic bit legal(logic [4:0] a, logic u, logic d);
    if (u && (a == 5'd24 || a == 5'd29)) return 1'b0;
    if (!d && (a == 5'd25 || a == 5'd30)) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [4:0] a);
    if (!legal(a, user_mode, dbg_access)) return 32'd0;
    if (a == 5'd0) return 32'd0;
    if (link_en && a == 5'd31) return link_data;
    if (wr_en && !link_en && wr_addr != 5'd0 && legal(wr_addr, user_mode, dbg_access)
        && wr_addr == a) return wr_data;
    return mdl[a];
  endfunction

  function automatic logic exp_viol();
    return (rd_en_a && !legal(rd_addr_a, user_mode, dbg_access)) ||
           (rd_en_b && !legal(rd_addr_b, user_mode, dbg_access)) ||
           (wr_en && !link_en && !legal(wr_addr, user_mode, dbg_access));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] ra, logic ea, logic [4:0] rb, logic eb,
                       logic [4:0] wa, logic [31:0] wd, logic we,
                       logic le, logic [31:0] ld, logic u, logic d);
    rd_addr_a = ra; rd_en_a = ea; rd_addr_b = rb; rd_en_b = eb;
    wr_addr = wa; wr_data = wd; wr_en = we;
    link_en = le; link_data = ld; user_mode = u; dbg_access = d;
  endtask

  task automatic step(string req);
    #1;
    check({req, " rd_data_a"}, rd_data_a, exp_rd(rd_addr_a));
    check({req, " rd_data_b"}, rd_data_b, exp_rd(rd_addr_b));
    check({req, " violation"}, {31'd0, violation}, {31'd0, exp_viol()});
    @(posedge clk);
    if (link_en) mdl[31] = link_data;
    else if (wr_en && wr_addr != 5'd0 && legal(wr_addr, user_mode, dbg_access))
      mdl[wr_addr] = wr_data;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(5'd0, 1'b0, 5'd0, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
    // R1: during reset, all words read zero
    for (int i = 0; i < 32; i += 2) begin
      drive(5'(i), 1'b1, 5'(i + 1), 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);
      #1;
      check("R1 reset read a", rd_data_a, 32'd0);
      check("R1 reset read b", rd_data_b, 32'd0);
      @(negedge clk);
    end
    idle();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] pick [10];
    pick = '{5'd0, 5'd24, 5'd25, 5'd29, 5'd30, 5'd31, 5'd1, 5'd2, 5'd3, 5'd26};
    void'($urandom(32'h5EED_1234));
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    do_reset();

    // R1: after release every word is still zero (supervisor + debug)
    for (int i = 0; i < 32; i += 2) begin
      drive(5'(i), 1'b1, 5'(i + 1), 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);
      step("R1 post-reset");
    end

    // R3: plain write then read on both ports
    drive(5'd5, 1'b1, 5'd6, 1'b1, 5'd5, 32'hDEAD_BEEF, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R3/R4 write r5");
    drive(5'd6, 1'b1, 5'd5, 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b0);
    step("R3 read r5");
    // R2: write to zero discarded
    drive(5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'd0, 1'b0, 1'b1);
    step("R2 write r0");
    drive(5'd0, 1'b1, 5'd5, 1'b0, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);
    step("R2 read r0");
    // R5: supervisor writes exc reg, user read blocked, user write blocked
    drive(5'd24, 1'b1, 5'd29, 1'b1, 5'd24, 32'h1111_2424, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R5 supervisor write r24");
    drive(5'd24, 1'b1, 5'd29, 1'b0, 5'd29, 32'h2929_0000, 1'b1, 1'b0, 32'd0, 1'b1, 1'b1);
    step("R5 user blocked");
    drive(5'd24, 1'b1, 5'd29, 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R5 supervisor readback");
    // R6: debug registers
    drive(5'd25, 1'b1, 5'd30, 1'b1, 5'd30, 32'h3030_ABCD, 1'b1, 1'b0, 32'd0, 1'b0, 1'b1);
    step("R6 debug write r30");
    drive(5'd30, 1'b1, 5'd25, 1'b0, 5'd25, 32'h2525_0000, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R6 non-debug blocked");
    drive(5'd30, 1'b1, 5'd25, 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b1, 1'b1);
    step("R6 debug readback user");
    // R7: disabled reads of blocked regs raise nothing
    drive(5'd24, 1'b0, 5'd30, 1'b0, 5'd7, 32'h7, 1'b1, 1'b0, 32'd0, 1'b1, 1'b0);
    step("R7 disabled reads quiet");
    // R8: link overrides a blocked write and bypasses to r31
    drive(5'd31, 1'b1, 5'd7, 1'b1, 5'd29, 32'hBAD0_BAD0, 1'b1, 1'b1, 32'h0000_4000, 1'b1, 1'b0);
    step("R8 link with write");
    drive(5'd29, 1'b0, 5'd31, 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b0);
    step("R8 link readback");
    // R4: bypass to both ports at once
    drive(5'd9, 1'b1, 5'd9, 1'b1, 5'd9, 32'h0909_0909, 1'b1, 1'b0, 32'd0, 1'b1, 1'b0);
    step("R4 dual bypass");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [4:0] ra, rb, wa;
      ra = ($urandom % 2) ? pick[$urandom % 10] : 5'($urandom);
      rb = ($urandom % 2) ? pick[$urandom % 10] : 5'($urandom);
      wa = ($urandom % 2) ? pick[$urandom % 10] : 5'($urandom);
      if ($urandom % 4 == 0) wa = ra;
      drive(ra, 1'($urandom), rb, 1'($urandom), wa, $urandom, 1'($urandom),
            ($urandom % 8 == 0), $urandom, 1'($urandom), 1'($urandom));
      step("R3 R4 R5 R6 R7 R8 random");
    end

    // R1: reset clears populated words
    do_reset();
    for (int i = 0; i < 32; i += 2) begin
      drive(5'(i), 1'b1, 5'(i + 1), 1'b1, 5'd0, 32'd0, 1'b0, 1'b0, 32'd0, 1'b0, 1'b1);
      step("R1 second reset");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule